// File: doc/BRIEF.md
# Configurable Pin Cell Bank

This block models a bank of universal pin cells for a programmable logic fabric. Each cell sits on one pin, modelled as three separate signals: a driven value, a drive enable and a sensed value. Its direction is chosen by configuration: input only, always-driving output, or tri-state bidirectional. In every direction, the sensed pin value reaches the fabric's global routing through one of three capture modes: combinational, registered or latched.

Every cell drives data from one of the fabric's logic outputs. It either picks any logic output through an output routing stage, or takes a fixed logic output through a bypass. It can invert that data before it reaches the pin. All bidirectional cells in the bank follow one shared group enable. The capture register uses the bank's I/O clock line, and that line may come from a dedicated clock pin or from a clock made in the fabric. An active-low global reset clears the stored capture values.

The capture selector works as a small per-cell state space with four states. The state is set by configuration and is not stepped by time. CAP_COMB passes the pin straight through. CAP_REG presents the value sampled at the last rising clock edge. CAP_LATCH presents the value last seen while the latch enable was high. CAP_ALT behaves as CAP_COMB. The only transitions are configuration writes between these states. Reset forces the stored value of CAP_REG and CAP_LATCH to zero.

Top module: `io_bank`

## Requirements
- R1: With capture code 0 (combinational), grp_in of a cell equals its pad_in in the same cycle, with no clock involved.
- R2: With capture code 1 (registered), grp_in takes the pad_in value sampled at each rising clk_io edge and holds it between edges.
- R3: With capture code 2 (latched), grp_in follows pad_in while lat_en is 1 and holds the last passed value while lat_en is 0, across clock edges.
- R4: While rst_n is 0, the registered and latched capture values are 0, and the clear takes effect at once, without waiting for a clock edge. After release, a registered cell updates only at the next rising edge, and a closed latch stays 0.
- R5: Direction code 0 never drives (pad_oe is 0), code 1 always drives (pad_oe is 1), code 2 drives exactly when grp_oe is 1, and code 3 behaves as code 0.
- R6: A single grp_oe input controls the drive enable of every bidirectional cell in the bank at the same time.
- R7: With the cell's invert bit at 1, pad_out is the complement of the selected source. With the bit at 0, it equals the source.
- R8: With route bit 1, the source of cell i is glb_out[cfg_idx field i], where field i is bits [3*i+2:3*i] by default. With route bit 0, the source is the bypass input glb_out[i mod NSRC].
- R9: The capture path is active in every direction, so a driving cell whose pin loops back presents its own driven value on grp_in.
- R10: Capture code 3 behaves as combinational capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | I/O clock line for the capture registers |
| rst_n | input | 1 | Active-low global reset; clears the capture storage |
| lat_en | input | 1 | Latch enable; 1 means transparent |
| grp_oe | input | 1 | Shared drive enable for the bidirectional cells |
| glb_out | input | NSRC | Logic array outputs available as drive sources |
| cfg_cap | input | 2*NCELL | Capture code per cell, 2 bits per cell |
| cfg_dir | input | 2*NCELL | Direction code per cell, 2 bits per cell |
| cfg_inv | input | NCELL | Output inversion per cell |
| cfg_route | input | NCELL | 1 selects the routing stage, 0 selects the bypass |
| cfg_idx | input | IW*NCELL | Routing-stage source index per cell |
| pad_in | input | NCELL | Sensed pin values |
| pad_out | output | NCELL | Values driven to the pins |
| pad_oe | output | NCELL | Pin drive enables |
| grp_in | output | NCELL | Captured pin values sent to global routing |

## Verification
Capture is driven with alternating and irregular pin words. The words are changed before an edge, after an edge and while the latch is closed, which separates a direct path from a sampled path and from a held path. The reset check mixes registered and latched cells in one word, so the first edge after release has to update only the registered half. Drive is checked with all four direction codes side by side under both levels of the group enable, and with two asymmetric source words under an alternating invert mask, so that a wrong bypass index, a wrong routing index or a missing inversion each gives a different word. A loop-back pin model checks the capture path while cells are driving.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

    typedef enum logic [1:0] {
        CAP_COMB  = 2'd0,
        CAP_REG   = 2'd1,
        CAP_LATCH = 2'd2,
        CAP_ALT   = 2'd3
    } cap_mode_e;

    typedef enum logic [1:0] {
        DIR_IN    = 2'd0,
        DIR_OUT   = 2'd1,
        DIR_BIDIR = 2'd2,
        DIR_RSVD  = 2'd3
    } dir_mode_e;

    typedef struct packed {
        cap_mode_e cap;
        dir_mode_e dir;
        logic      inv;
        logic      route;
    } cell_cfg_t;

endpackage

// File: rtl/iocell_capture.sv
module iocell_capture
    import iocell_pkg::*;
(
    input  logic      clk_io,
    input  logic      rst_n,
    input  logic      lat_en,
    input  cap_mode_e cap_mode,
    input  logic      pin,
    output logic      captured
);

    logic reg_q;
    logic lat_q;

    // Sampled capture store
    always_ff @(posedge clk_io or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= 1'b0;
        end else begin
            reg_q <= pin;
        end
    end

    // Level-sensitive capture store
    always_latch begin
        if (!rst_n) begin
            lat_q = 1'b0;
        end else if (lat_en) begin
            lat_q = pin;
        end
    end

    // Capture state selects what the routing pool sees
    always_comb begin
        unique case (cap_mode)
            CAP_REG:   captured = reg_q;
            CAP_LATCH: captured = lat_q;
            default:   captured = pin;
        endcase
    end

    // R2: registered capture presents the previous edge's pin value
    p_reg_sample_r2: assert property (@(posedge clk_io) disable iff (!rst_n)
        (cap_mode == CAP_REG && $past(cap_mode) == CAP_REG && $past(rst_n))
        |-> captured == $past(pin));

    // R3: closed latch does not move
    p_latch_hold_r3: assert property (@(posedge clk_io) disable iff (!rst_n)
        (cap_mode == CAP_LATCH && $past(cap_mode) == CAP_LATCH &&
         !lat_en && !$past(lat_en) && $past(rst_n))
        |-> $stable(captured));

endmodule

// File: rtl/iocell_drive.sv
module iocell_drive
    import iocell_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IW   = 3,
    parameter int BYP  = 0
) (
    input  logic [NSRC-1:0] glb_out,
    input  logic            route_sel,
    input  logic [IW-1:0]   idx,
    input  logic            inv,
    input  dir_mode_e       dir_mode,
    input  logic            grp_oe,
    output logic            pad_out,
    output logic            pad_oe
);

    logic routed;
    logic src;

    // Output routing stage: any logic output by index
    generate
        if (NSRC == (1 << IW)) begin : g_full
            assign routed = glb_out[idx];
        end else begin : g_part
            assign routed = (int'(idx) < NSRC) ? glb_out[idx] : 1'b0;
        end
    endgenerate

    always_comb begin
        src     = route_sel ? routed : glb_out[BYP];
        pad_out = src ^ inv;
    end

    // Direction state decides the drive enable
    always_comb begin
        unique case (dir_mode)
            DIR_OUT:   pad_oe = 1'b1;
            DIR_BIDIR: pad_oe = grp_oe;
            default:   pad_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/iocell.sv
module iocell
    import iocell_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IW   = 3,
    parameter int CELL = 0
) (
    input  logic            clk_io,
    input  logic            rst_n,
    input  logic            lat_en,
    input  logic            grp_oe,
    input  logic [NSRC-1:0] glb_out,
    input  cell_cfg_t       cfg,
    input  logic [IW-1:0]   idx,
    input  logic            pad_in,
    output logic            pad_out,
    output logic            pad_oe,
    output logic            grp_in
);

    localparam int BYP = CELL % NSRC;

    iocell_capture i_capture (
        .clk_io   (clk_io),
        .rst_n    (rst_n),
        .lat_en   (lat_en),
        .cap_mode (cfg.cap),
        .pin      (pad_in),
        .captured (grp_in)
    );

    iocell_drive #(
        .NSRC (NSRC),
        .IW   (IW),
        .BYP  (BYP)
    ) i_drive (
        .glb_out   (glb_out),
        .route_sel (cfg.route),
        .idx       (idx),
        .inv       (cfg.inv),
        .dir_mode  (cfg.dir),
        .grp_oe    (grp_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

endmodule

// File: rtl/io_bank.sv
module io_bank
    import iocell_pkg::*;
#(
    parameter int NCELL = 16,
    parameter int NSRC  = 8,
    localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                clk_io,
    input  logic                rst_n,
    input  logic                lat_en,
    input  logic                grp_oe,
    input  logic [NSRC-1:0]     glb_out,
    input  logic [2*NCELL-1:0]  cfg_cap,
    input  logic [2*NCELL-1:0]  cfg_dir,
    input  logic [NCELL-1:0]    cfg_inv,
    input  logic [NCELL-1:0]    cfg_route,
    input  logic [IW*NCELL-1:0] cfg_idx,
    input  logic [NCELL-1:0]    pad_in,
    output logic [NCELL-1:0]    pad_out,
    output logic [NCELL-1:0]    pad_oe,
    output logic [NCELL-1:0]    grp_in
);

    generate
        for (genvar g = 0; g < NCELL; g++) begin : g_cell
            cell_cfg_t cell_cfg;

            assign cell_cfg = '{
                cap:   cap_mode_e'(cfg_cap[2*g +: 2]),
                dir:   dir_mode_e'(cfg_dir[2*g +: 2]),
                inv:   cfg_inv[g],
                route: cfg_route[g]
            };

            iocell #(
                .NSRC (NSRC),
                .IW   (IW),
                .CELL (g)
            ) i_cell (
                .clk_io  (clk_io),
                .rst_n   (rst_n),
                .lat_en  (lat_en),
                .grp_oe  (grp_oe),
                .glb_out (glb_out),
                .cfg     (cell_cfg),
                .idx     (cfg_idx[IW*g +: IW]),
                .pad_in  (pad_in[g]),
                .pad_out (pad_out[g]),
                .pad_oe  (pad_oe[g]),
                .grp_in  (grp_in[g])
            );

            // R5: input-only and reserved codes never drive
            p_in_no_drive_r5: assert property (@(posedge clk_io) disable iff (!rst_n)
                (cfg_dir[2*g +: 2] == DIR_IN || cfg_dir[2*g +: 2] == DIR_RSVD)
                |-> !pad_oe[g]);

            // R5: output code always drives
            p_out_drive_r5: assert property (@(posedge clk_io) disable iff (!rst_n)
                (cfg_dir[2*g +: 2] == DIR_OUT) |-> pad_oe[g]);

            // R6: bidirectional cells follow the shared group enable
            p_bidir_group_r6: assert property (@(posedge clk_io) disable iff (!rst_n)
                (cfg_dir[2*g +: 2] == DIR_BIDIR) |-> (pad_oe[g] == grp_oe));

            // R1 / R10: combinational capture shows the pin directly
            p_comb_path_r1: assert property (@(posedge clk_io) disable iff (!rst_n)
                (cfg_cap[2*g +: 2] == CAP_COMB || cfg_cap[2*g +: 2] == CAP_ALT)
                |-> (grp_in[g] == pad_in[g]));
        end
    endgenerate

endmodule

// File: tb/test_io_bank.sv
module test_io_bank;

    localparam int N    = 16;
    localparam int NS   = 8;
    localparam int IW   = 3;

    logic            clk_io = 1'b0;
    logic            rst_n  = 1'b0;
    logic            lat_en = 1'b0;
    logic            grp_oe = 1'b0;
    logic [NS-1:0]   glb_out = '0;
    logic [2*N-1:0]  cfg_cap = '0;
    logic [2*N-1:0]  cfg_dir = '0;
    logic [N-1:0]    cfg_inv = '0;
    logic [N-1:0]    cfg_route = '0;
    logic [IW*N-1:0] cfg_idx = '0;
    logic [N-1:0]    ext = '0;
    logic [N-1:0]    pad_in;
    logic [N-1:0]    pad_out;
    logic [N-1:0]    pad_oe;
    logic [N-1:0]    grp_in;

    int n_chk  = 0;
    int n_fail = 0;

    // Pin model: a driving cell sees its own value, otherwise the outside
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    always #10 clk_io = ~clk_io;

    io_bank i_io_bank (
        .clk_io    (clk_io),
        .rst_n     (rst_n),
        .lat_en    (lat_en),
        .grp_oe    (grp_oe),
        .glb_out   (glb_out),
        .cfg_cap   (cfg_cap),
        .cfg_dir   (cfg_dir),
        .cfg_inv   (cfg_inv),
        .cfg_route (cfg_route),
        .cfg_idx   (cfg_idx),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .grp_in    (grp_in)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cap_all(input logic [1:0] code);
        for (int i = 0; i < N; i++) cfg_cap[2*i +: 2] = code;
    endtask

    task automatic set_dir_all(input logic [1:0] code);
        for (int i = 0; i < N; i++) cfg_dir[2*i +: 2] = code;
    endtask

    function automatic logic [N-1:0] exp_drive(input logic [NS-1:0] g,
                                               input logic [N-1:0] inv,
                                               input logic [N-1:0] rte,
                                               input logic [IW*N-1:0] ix);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            r[i] = (rte[i] ? g[ix[IW*i +: IW]] : g[i % NS]) ^ inv[i];
        end
        return r;
    endfunction

    // R4: reset state with registered and latched cells
    task automatic t_reset_state();
        for (int i = 0; i < N; i++) cfg_cap[2*i +: 2] = (i % 2 == 0) ? 2'd1 : 2'd2;
        set_dir_all(2'd0);
        ext    = '1;
        lat_en = 1'b1;
        repeat (3) @(posedge clk_io);
        @(negedge clk_io);
        chk("R4 reset state", grp_in, '0);
        rst_n = 1'b1;
        @(posedge clk_io);
        @(posedge clk_io);
        lat_en = 1'b0;
        @(posedge clk_io);
    endtask

    // R1 and R10: direct capture under two words
    task automatic t_comb();
        @(negedge clk_io);
        set_cap_all(2'd0);
        set_dir_all(2'd0);
        ext = 16'hA5C3;
        #1 chk("R1 comb word A", grp_in, 16'hA5C3);
        ext = 16'h5A3C;
        #1 chk("R1 comb word B", grp_in, 16'h5A3C);
        set_cap_all(2'd3);
        ext = 16'h0F96;
        #1 chk("R10 alt code comb", grp_in, 16'h0F96);
    endtask

    // R2: sample at edge, hold between edges
    task automatic t_reg();
        @(negedge clk_io);
        set_cap_all(2'd1);
        ext = 16'h3C71;
        @(posedge clk_io);
        @(negedge clk_io);
        chk("R2 sampled at edge", grp_in, 16'h3C71);
        ext = 16'hC28E;
        #1 chk("R2 hold between edges", grp_in, 16'h3C71);
        @(posedge clk_io);
        #1 chk("R2 new sample", grp_in, 16'hC28E);
    endtask

    // R3: transparent and hold
    task automatic t_latch();
        @(negedge clk_io);
        set_cap_all(2'd2);
        lat_en = 1'b1;
        ext = 16'h1234;
        #1 chk("R3 transparent A", grp_in, 16'h1234);
        ext = 16'hBEEF;
        #1 chk("R3 transparent B", grp_in, 16'hBEEF);
        @(negedge clk_io);
        lat_en = 1'b0;
        #1 ext = 16'h6001;
        #1 chk("R3 hold while closed", grp_in, 16'hBEEF);
        @(posedge clk_io);
        @(negedge clk_io);
        chk("R3 hold across edge", grp_in, 16'hBEEF);
        lat_en = 1'b1;
        #1 chk("R3 reopen", grp_in, 16'h6001);
        @(posedge clk_io);
        @(negedge clk_io);
        lat_en = 1'b0;
        @(posedge clk_io);
    endtask

    // R4: asynchronous clear, release behaviour
    task automatic t_async_reset();
        @(negedge clk_io);
        for (int i = 0; i < N; i++) cfg_cap[2*i +: 2] = (i % 2 == 0) ? 2'd1 : 2'd2;
        ext    = '1;
        lat_en = 1'b1;
        @(posedge clk_io);
        @(negedge clk_io);
        lat_en = 1'b0;
        @(posedge clk_io);
        @(negedge clk_io);
        chk("R4 loaded before reset", grp_in, '1);
        #3 rst_n = 1'b0;
        #1 chk("R4 clear without edge", grp_in, '0);
        @(posedge clk_io);
        @(negedge clk_io);
        chk("R4 clear holds in reset", grp_in, '0);
        rst_n = 1'b1;
        #1 chk("R4 no update before edge", grp_in, '0);
        @(posedge clk_io);
        #1 chk("R4 only registered cells reload", grp_in, 16'h5555);
    endtask

    // R5, R6, R9: direction codes side by side under both group enable levels
    task automatic t_direction();
        @(negedge clk_io);
        set_cap_all(2'd0);
        for (int i = 0; i < N; i++) cfg_dir[2*i +: 2] = 2'(i / 4);
        glb_out   = '1;
        cfg_inv   = '0;
        cfg_route = '0;
        ext       = '0;
        grp_oe    = 1'b0;
        #1 chk("R5 enable with group off", pad_oe, 16'h00F0);
        chk("R9 readback group off", grp_in, 16'h00F0);
        grp_oe = 1'b1;
        #1 chk("R6 enable with group on", pad_oe, 16'h0FF0);
        chk("R9 readback group on", grp_in, 16'h0FF0);
        @(posedge clk_io);
        @(negedge clk_io);
        grp_oe = 1'b0;
        #1 chk("R6 group off again", pad_oe, 16'h00F0);
    endtask

    // R7, R8: inversion, bypass and routing stage
    task automatic t_source();
        logic [IW*N-1:0] ix;
        @(negedge clk_io);
        set_dir_all(2'd1);
        cfg_inv   = 16'hAAAA;
        cfg_route = '0;
        glb_out   = 8'hB2;
        #1 chk("R7 R8 bypass inverted word A", pad_out, exp_drive(8'hB2, 16'hAAAA, '0, cfg_idx));
        glb_out = 8'h4D;
        #1 chk("R7 R8 bypass inverted word B", pad_out, exp_drive(8'h4D, 16'hAAAA, '0, cfg_idx));
        for (int i = 0; i < N; i++) ix[IW*i +: IW] = IW'((i * 3 + 1) % NS);
        cfg_idx   = ix;
        cfg_inv   = '0;
        cfg_route = '1;
        glb_out   = 8'hB2;
        #1 chk("R8 routed", pad_out, exp_drive(8'hB2, '0, '1, ix));
        cfg_route = 16'h0F0F;
        cfg_inv   = 16'hFF00;
        #1 chk("R7 R8 mixed routes", pad_out, exp_drive(8'hB2, 16'hFF00, 16'h0F0F, ix));
    endtask

    // R9: registered readback of a driving cell
    task automatic t_readback();
        logic [N-1:0] drv;
        @(negedge clk_io);
        set_dir_all(2'd1);
        set_cap_all(2'd1);
        cfg_route = '0;
        cfg_inv   = 16'h3C3C;
        glb_out   = 8'h96;
        drv       = exp_drive(8'h96, 16'h3C3C, '0, cfg_idx);
        ext       = ~drv;
        @(posedge clk_io);
        #1 chk("R9 registered readback", grp_in, drv);
    endtask

    initial begin
        t_reset_state();
        t_comb();
        t_reg();
        t_latch();
        t_async_reset();
        t_direction();
        t_source();
        t_readback();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_io);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule